// File: doc/BRIEF.md
# Power Feedback Fetch Governor

The governor sits between a core's power estimator and its fetch stage. Every fixed number of cycles it takes a new power estimate and a set of per-thread throughput (IPC) indicators. It compares the estimate with thresholds that are fixed percentages of a target power. From the result it drives per-thread branch-prediction enables and per-thread fetch enables. As the estimate rises, the core gives up speculation first, then individual threads, then all fetch. It regains them in reverse order as the estimate falls.

A static policy input picks one of three throttling schemes. The global scheme has two thresholds. The staged-prediction scheme removes prediction from the slowest thread first. The staged-fetch scheme parks threads one at a time, slowest first. Every scheme halts all fetch at 110% of target. Throttling decisions use only the most recent sample, so the outputs hold steady for the whole sampling window.

Top module: `fetch_power_governor`

## Requirements
- R1: While reset is held, and after reset until the first sample is taken, every bit of `bp_en_o` and `fetch_en_o` is 1.
- R2: `power_i` and `ipc_i` are captured only on every SAMPLE_PERIOD-th rising clock edge after reset release (default 5). The outputs change only right after such an edge and otherwise ignore input changes.
- R3: Thresholds are TARGET_PWR*p/100 in integer arithmetic for p = 80, 90, 100 and 110. A level counts as crossed when the sampled power is greater than or equal to it (defaults 800, 900, 1000, 1100).
- R4: Under the global policy, a sample at or above the 90% level clears every `bp_en_o` bit.
- R5: Under the global policy, a sample at or above the 110% level clears every `fetch_en_o` bit. A later sample below 110% but at or above 90% sets fetch again with prediction still off.
- R6: Under the global policy, a sample below the 90% level sets every `bp_en_o` and `fetch_en_o` bit.
- R7: Under the staged-prediction policy, a sample in [90%, 100%) clears `bp_en_o` only for the thread with the lowest sampled IPC. On a tie, the lowest thread index is the one cleared.
- R8: Under the staged-prediction policy, a sample at or above 100% clears all `bp_en_o` bits.
- R9: Under the staged-fetch policy, `bp_en_o` stays all ones. The number of halted threads k equals the count of crossed levels among 80%, 90% and 100%, capped at NUM_THREADS-1. The k threads halted are the first k in ascending order of sampled IPC, with ties broken by lower index first.
- R10: Under every policy, a sample at or above 110% clears every `fetch_en_o` bit.
- R11: `policy_i` codes are 0 global, 1 staged prediction, 2 staged fetch, and 3 behaves as 0. The input is read as static and changes only while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| policy_i | input | 2 | Throttling policy code, static outside reset |
| power_i | input | PWR_W | Current power estimate |
| ipc_i | input | NUM_THREADS*IPC_W | Per-thread IPC indicators, thread 0 in the low bits |
| bp_en_o | output | NUM_THREADS | Per-thread branch-prediction enable |
| fetch_en_o | output | NUM_THREADS | Per-thread fetch enable |

## Verification
A misaligned sample counter shows up as outputs moving one or more cycles off the sampling grid. That is visible within one window of SAMPLE_PERIOD cycles after reset. A wrong threshold or comparison sense flips an enable exactly at a boundary sample, such as 899 against 900 or 1099 against 1100, in the cycle after that sample is taken. A wrong IPC ranking parks or de-speculates the wrong thread. Tied IPC values expose this directly because the lower index must lose first. Every one of these faults reaches the output ports within a single sampling window.

// File: rtl/fpg_pkg.sv
package fpg_pkg;
  typedef enum logic [1:0] {
    POL_GLOBAL       = 2'd0,
    POL_STAGED_BP    = 2'd1,
    POL_STAGED_FETCH = 2'd2,
    POL_GLOBAL_ALT   = 2'd3
  } policy_e;

  // crossing vector bit positions
  localparam int LVL_80  = 0;
  localparam int LVL_90  = 1;
  localparam int LVL_100 = 2;
  localparam int LVL_110 = 3;
  localparam int NUM_LVL = 4;
endpackage

// File: rtl/fpg_sampler.sv
module fpg_sampler #(
  parameter int PWR_W  = 12,
  parameter int NT     = 4,
  parameter int IPC_W  = 4,
  parameter int PERIOD = 5
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [PWR_W-1:0]      power_i,
  input  logic [NT*IPC_W-1:0]   ipc_i,
  output logic [PWR_W-1:0]      power_q_o,
  output logic [NT*IPC_W-1:0]   ipc_q_o
);
  localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             take;

  assign take = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      power_q_o <= '0;
      ipc_q_o   <= '0;
    end else begin
      cnt_q <= take ? '0 : cnt_q + 1'b1;
      if (take) begin
        power_q_o <= power_i;
        ipc_q_o   <= ipc_i;
      end
    end
  end
endmodule

// File: rtl/fpg_levels.sv
module fpg_levels
  import fpg_pkg::*;
#(
  parameter int PWR_W      = 12,
  parameter int TARGET_PWR = 1000
) (
  input  logic [PWR_W-1:0]   power_i,
  output logic [NUM_LVL-1:0] crossed_o
);
  localparam int PCT [NUM_LVL] = '{80, 90, 100, 110};

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    localparam longint unsigned TH = (longint'(TARGET_PWR) * PCT[l]) / 100;
    assign crossed_o[l] = (64'(power_i) >= 64'(TH));
  end
endmodule

// File: rtl/fpg_rank.sv
module fpg_rank #(
  parameter int NT     = 4,
  parameter int IPC_W  = 4,
  parameter int RANK_W = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic [NT*IPC_W-1:0]          ipc_i,
  output logic [NT-1:0][RANK_W-1:0]    rank_o
);
  logic [NT-1:0][IPC_W-1:0] ipc;
  assign ipc = ipc_i;

  // rank 0 = lowest IPC, ties resolved toward lower index
  for (genvar i = 0; i < NT; i++) begin : g_rank
    always_comb begin
      int cnt;
      cnt = 0;
      for (int j = 0; j < NT; j++) begin
        if (j != i) begin
          if ((ipc[j] < ipc[i]) || ((ipc[j] == ipc[i]) && (j < i))) cnt++;
        end
      end
      rank_o[i] = RANK_W'(cnt);
    end
  end
endmodule

// File: rtl/fetch_power_governor.sv
module fetch_power_governor
  import fpg_pkg::*;
#(
  parameter int NUM_THREADS   = 4,
  parameter int PWR_W         = 12,
  parameter int IPC_W         = 4,
  parameter int TARGET_PWR    = 1000,
  parameter int SAMPLE_PERIOD = 5
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [1:0]                   policy_i,
  input  logic [PWR_W-1:0]             power_i,
  input  logic [NUM_THREADS*IPC_W-1:0] ipc_i,
  output logic [NUM_THREADS-1:0]       bp_en_o,
  output logic [NUM_THREADS-1:0]       fetch_en_o
);
  localparam int RANK_W   = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1;
  localparam int MAX_STOP = NUM_THREADS - 1;

  logic [PWR_W-1:0]                 power_q;
  logic [NUM_THREADS*IPC_W-1:0]     ipc_q;
  logic [NUM_LVL-1:0]               crossed;
  logic [NUM_THREADS-1:0][RANK_W-1:0] rank;
  policy_e                          pol;

  fpg_sampler #(
    .PWR_W(PWR_W), .NT(NUM_THREADS), .IPC_W(IPC_W), .PERIOD(SAMPLE_PERIOD)
  ) u_sampler (
    .clk_i(clk_i), .rst_ni(rst_ni), .power_i(power_i), .ipc_i(ipc_i),
    .power_q_o(power_q), .ipc_q_o(ipc_q)
  );

  fpg_levels #(.PWR_W(PWR_W), .TARGET_PWR(TARGET_PWR)) u_levels (
    .power_i(power_q), .crossed_o(crossed)
  );

  fpg_rank #(.NT(NUM_THREADS), .IPC_W(IPC_W), .RANK_W(RANK_W)) u_rank (
    .ipc_i(ipc_q), .rank_o(rank)
  );

  assign pol = policy_e'(policy_i);

  always_comb begin
    int nstop;
    nstop = int'(crossed[LVL_80]) + int'(crossed[LVL_90]) + int'(crossed[LVL_100]);
    if (nstop > MAX_STOP) nstop = MAX_STOP;
    bp_en_o    = '1;
    fetch_en_o = {NUM_THREADS{!crossed[LVL_110]}};
    unique case (pol)
      POL_STAGED_BP: begin
        for (int i = 0; i < NUM_THREADS; i++)
          bp_en_o[i] = !(crossed[LVL_100] || (crossed[LVL_90] && (rank[i] == '0)));
      end
      POL_STAGED_FETCH: begin
        for (int i = 0; i < NUM_THREADS; i++)
          fetch_en_o[i] = !crossed[LVL_110] && (int'(rank[i]) >= nstop);
      end
      default: begin
        bp_en_o = {NUM_THREADS{!crossed[LVL_90]}};
      end
    endcase
  end
endmodule

// File: rtl/fpg_checker.sv
module fpg_checker #(
  parameter int NT     = 4,
  parameter int PERIOD = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    policy_i,
  input logic [NT-1:0] bp_en_o,
  input logic [NT-1:0] fetch_en_o
);
  localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

  logic [CNT_W-1:0] ck;
  logic             sampled;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ck      <= '0;
      sampled <= 1'b0;
    end else begin
      if (ck == CNT_W'(PERIOD - 1)) begin
        ck      <= '0;
        sampled <= 1'b1;
      end else begin
        ck <= ck + 1'b1;
      end
    end
  end

  p_enabled_before_sample_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sampled |-> (&bp_en_o && &fetch_en_o));

  p_hold_between_samples_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ck != CNT_W'(PERIOD - 1)) |=> ($stable(bp_en_o) && $stable(fetch_en_o)));

  p_global_uniform_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (policy_i == 2'd0 || policy_i == 2'd3) |-> (bp_en_o == '0 || &bp_en_o));

  p_halt_implies_nospec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((policy_i == 2'd0 || policy_i == 2'd3) && fetch_en_o == '0) |-> (bp_en_o == '0));

  p_staged_bp_count_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (policy_i == 2'd1) |->
      ($countones(bp_en_o) == NT || $countones(bp_en_o) == NT - 1 || bp_en_o == '0));

  p_staged_bp_halt_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (policy_i == 2'd1 && fetch_en_o == '0) |-> (bp_en_o == '0));

  p_staged_fetch_spec_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (policy_i == 2'd2) |-> &bp_en_o);

  p_policy_static_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> $stable(policy_i));
endmodule

bind fetch_power_governor fpg_checker #(.NT(NUM_THREADS), .PERIOD(SAMPLE_PERIOD)) u_fpg_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .policy_i(policy_i),
  .bp_en_o(bp_en_o), .fetch_en_o(fetch_en_o)
);

// File: tb/fetch_power_governor_bench.sv
module fetch_power_governor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NT     = 4;
  localparam int PWR_W  = 12;
  localparam int IPC_W  = 4;
  localparam int TARGET = 1000;
  localparam int PERIOD = 5;
  localparam int WATCHDOG = 20000;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic [1:0]           policy = 2'd0;
  logic [PWR_W-1:0]     power = '0;
  logic [IPC_W-1:0]     ipc_drv [NT];
  logic [NT*IPC_W-1:0]  ipc_flat;
  logic [NT-1:0]        bp_en, fetch_en;

  int    checks = 0;
  int    fails  = 0;
  int    cycles = 0;
  string cur_req = "R1";

  int m_cnt;
  int m_pwr;
  int m_ipc [NT];

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb
    for (int t = 0; t < NT; t++) ipc_flat[t*IPC_W +: IPC_W] = ipc_drv[t];

  fetch_power_governor #(
    .NUM_THREADS(NT), .PWR_W(PWR_W), .IPC_W(IPC_W),
    .TARGET_PWR(TARGET), .SAMPLE_PERIOD(PERIOD)
  ) u_fetch_power_governor (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(policy), .power_i(power),
    .ipc_i(ipc_flat), .bp_en_o(bp_en), .fetch_en_o(fetch_en)
  );

  // reference: sample every PERIOD-th edge after reset (R2)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0;
      m_pwr <= 0;
      for (int t = 0; t < NT; t++) m_ipc[t] <= 0;
    end else if (m_cnt == PERIOD - 1) begin
      m_cnt <= 0;
      m_pwr <= int'(power);
      for (int t = 0; t < NT; t++) m_ipc[t] <= int'(ipc_drv[t]);
    end else begin
      m_cnt <= m_cnt + 1;
    end
  end

  function automatic int th(input int pct);
    return TARGET * pct / 100; // R3
  endfunction

  task automatic expect_outs(output logic [NT-1:0] bp, output logic [NT-1:0] fe);
    int order[$];
    int k;
    int pos;
    for (int t = 0; t < NT; t++) begin
      pos = order.size();
      for (int q = 0; q < order.size(); q++)
        if (m_ipc[order[q]] > m_ipc[t]) begin pos = q; break; end
      order.insert(pos, t);
    end
    bp = '1;
    fe = (m_pwr >= th(110)) ? '0 : '1;  // R10
    case (policy)
      2'd1: begin
        if (m_pwr >= th(100)) bp = '0;
        else if (m_pwr >= th(90)) bp[order[0]] = 1'b0;
      end
      2'd2: begin
        k = (m_pwr >= th(80)) + (m_pwr >= th(90)) + (m_pwr >= th(100));
        if (k > NT - 1) k = NT - 1;
        for (int q = 0; q < k; q++) fe[order[q]] = 1'b0;
      end
      default: if (m_pwr >= th(90)) bp = '0;
    endcase
  endtask

  always @(negedge clk) begin
    logic [NT-1:0] ebp, efe;
    cycles++;
    expect_outs(ebp, efe);
    checks++;
    if (bp_en !== ebp || fetch_en !== efe) begin
      fails++;
      $display("FAIL %s: bp_en=%b expected %b, fetch_en=%b expected %b (pwr sample %0d)",
               cur_req, bp_en, ebp, fetch_en, efe, m_pwr);
    end
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: ran %0d cycles expected at most %0d", cycles, WATCHDOG);
      $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
      $finish;
    end
  end

  task automatic do_reset(input logic [1:0] pol);
    @(negedge clk);
    rst_n  = 1'b0;
    policy = pol;   // R11: policy only changes in reset
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic hold(input int pw, input string tag);
    cur_req = tag;
    power   = PWR_W'(pw);
    repeat (2 * PERIOD) @(negedge clk);
  endtask

  task automatic set_ipc(input int a, input int b, input int c, input int d);
    ipc_drv[0] = IPC_W'(a); ipc_drv[1] = IPC_W'(b);
    ipc_drv[2] = IPC_W'(c); ipc_drv[3] = IPC_W'(d);
  endtask

  initial begin
    set_ipc(1, 2, 3, 4);
    // R1: high power before the first sample must not throttle
    do_reset(2'd0);
    cur_req = "R1";
    power = PWR_W'(1500);
    repeat (PERIOD - 1) @(negedge clk);
    // global policy sweep
    hold(500,  "R6");
    hold(900,  "R4");
    hold(899,  "R6");
    hold(1100, "R5");
    hold(1099, "R5");
    hold(1500, "R10");
    hold(100,  "R6");
    // R2: inputs wiggle between samples
    cur_req = "R2";
    for (int n = 0; n < 6 * PERIOD; n++) begin
      power = PWR_W'((n % 3 == 0) ? 1200 : ((n % 3 == 1) ? 850 : 300));
      @(negedge clk);
    end
    // staged prediction, tie between threads 1 and 2
    do_reset(2'd1);
    set_ipc(5, 3, 3, 7);
    hold(899,  "R7");
    hold(900,  "R7");
    hold(999,  "R7");
    hold(1000, "R8");
    hold(1100, "R8");
    hold(950,  "R7");
    set_ipc(2, 9, 9, 1);
    hold(950,  "R7");
    // staged fetch
    do_reset(2'd2);
    set_ipc(9, 2, 6, 2);
    hold(799,  "R9");
    hold(800,  "R9");
    hold(900,  "R9");
    hold(1000, "R9");
    hold(3000, "R9");
    hold(1100, "R10");
    hold(850,  "R9");
    cur_req = "R2";
    for (int n = 0; n < 4 * PERIOD; n++) begin
      set_ipc(n % 16, (n * 3) % 16, (n * 5) % 16, (n * 7) % 16);
      power = PWR_W'(800 + 50 * (n % 7));
      @(negedge clk);
    end
    // alternate global code
    do_reset(2'd3);
    hold(900,  "R11");
    hold(1100, "R11");
    hold(700,  "R11");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule